// File: doc/BRIEF.md
# Raster Line Event and Reload Trigger Controller

This block sits beside a raster timing generator and watches its current horizontal and vertical position. Software programs a set of line numbers; when the scan reaches one of them at the start of the line, the block records a sticky event bit. Each event bit can be unmasked to drive a single combined interrupt line. Software clears event bits by writing ones to a dedicated clear port.

Two further programmable lines produce single-cycle reload trigger pulses. One serves a single-buffered register set and the other a double-buffered one, and each tells an external reload engine when to start. These pulses are produced only while the frame-running flag is high. Register access uses a plain write strobe and a read strobe, and read data is returned one cycle after the read strobe.

Top module: `line_event_ctrl`

## Requirements
- R1: After reset the status bits, mask bits, interrupt output, both reload pulses, every line register and the reload-line register are all zero.
- R2: Word addresses are 0 status (read only), 1 clear (write only, reads 0), 2 mask (bits 3:0), 3 reload lines (double-buffer line in bits 12:0, single-buffer line in bits 28:16), and 4+i for the line register of event i (line in bits 28:16). Reads return the stored fields, with all other bits zero, one cycle after rd_en.
- R3: Event i fires on a cycle where pos_x is 0 and pos_y equals its programmed line and that condition was false on the previous cycle. Holding the position there gives no further event.
- R4: A firing event sets its status bit whatever the mask holds.
- R5: Writing 1 to bit i of the clear address clears status bit i. Writing 0 leaves it unchanged, and an uncleared status bit stays set.
- R6: When an event and a clear write hit the same status bit in the same cycle, the bit ends up set.
- R7: irq equals the OR over all bits of status AND mask, registered one cycle. Unmasking a stale status bit raises irq.
- R8: reload_db pulses high for exactly one cycle, one cycle after the scan reaches the double-buffer line at x 0. reload_sb does the same for the single-buffer line. The two pulses are independent.
- R9: While frame_run is low, neither reload pulse is produced.
- R10: Line 0 is a valid trigger line for both the line events and the reload triggers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_x | input | 13 | Current horizontal position |
| pos_y | input | 13 | Current vertical line |
| frame_run | input | 1 | Raster running flag |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after rd_en |
| irq | output | 1 | Combined masked interrupt |
| reload_sb | output | 1 | Single-buffer reload trigger pulse |
| reload_db | output | 1 | Double-buffer reload trigger pulse |

## Verification
A line event and a software clear of the same status bit can land in the same cycle. The bench provokes this by moving the scan onto line event 3's line in the same cycle that it writes a one to that bit of the clear address. It judges the result by reading status back afterwards and expecting the bit still set. It also holds the position on a trigger line across a clear to show that no second event is produced.

// File: rtl/lec_pkg.sv
package lec_pkg;
    // word addresses
    localparam int ADR_STATUS    = 0;
    localparam int ADR_CLEAR     = 1;
    localparam int ADR_MASK      = 2;
    localparam int ADR_RELOAD    = 3;
    localparam int ADR_LINE_BASE = 4;
    // field positions
    localparam int LINE_LSB = 16;
    localparam int DB_LSB   = 0;
    localparam int SB_LSB   = 16;
endpackage

// File: rtl/line_match.sv
module line_match #(
    parameter int COORD_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COORD_W-1:0] pos_x,
    input  logic [COORD_W-1:0] pos_y,
    input  logic [COORD_W-1:0] line,
    output logic               fire
);
    logic hit_d, hit_q;

    always_comb begin
        hit_d = (pos_x == '0) && (pos_y == line);
        fire  = hit_d && !hit_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit_d;
    end
endmodule

// File: rtl/evt_status.sv
module evt_status #(
    parameter int N_LINES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] evt,
    input  logic               clr_we,
    input  logic [N_LINES-1:0] clr_bits,
    input  logic               mask_we,
    input  logic [N_LINES-1:0] mask_wr,
    output logic [N_LINES-1:0] status_q,
    output logic [N_LINES-1:0] mask_q,
    output logic               irq_q
);
    typedef struct packed {
        logic [N_LINES-1:0] status;
        logic [N_LINES-1:0] mask;
        logic               irq;
    } ev_t;

    ev_t ev_d, ev_q;

    always_comb begin
        ev_d = ev_q;
        // clear first, then set: an event in the same cycle wins
        if (clr_we) ev_d.status = ev_d.status & ~clr_bits;
        ev_d.status = ev_d.status | evt;
        if (mask_we) ev_d.mask = mask_wr;
        ev_d.irq = |(ev_q.status & ev_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end

    assign status_q = ev_q.status;
    assign mask_q   = ev_q.mask;
    assign irq_q    = ev_q.irq;
endmodule

// File: rtl/line_event_ctrl.sv
module line_event_ctrl #(
    parameter int N_LINES = 4,
    parameter int COORD_W = 13,
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COORD_W-1:0] pos_x,
    input  logic [COORD_W-1:0] pos_y,
    input  logic               frame_run,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq,
    output logic               reload_sb,
    output logic               reload_db
);
    import lec_pkg::*;

    typedef struct packed {
        logic [N_LINES-1:0][COORD_W-1:0] line;
        logic [COORD_W-1:0]              db_line;
        logic [COORD_W-1:0]              sb_line;
        logic                            pulse_db;
        logic                            pulse_sb;
        logic [DATA_W-1:0]               rdata;
    } st_t;

    st_t st_d, st_q;

    logic [N_LINES-1:0] line_evt;
    logic [N_LINES-1:0] status_q;
    logic [N_LINES-1:0] mask_q;
    logic               fire_db, fire_sb;
    logic               clr_we, mask_we;

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        line_match #(.COORD_W(COORD_W)) u_match (
            .clk   (clk),
            .rst_n (rst_n),
            .pos_x (pos_x),
            .pos_y (pos_y),
            .line  (st_q.line[i]),
            .fire  (line_evt[i])
        );
    end

    line_match #(.COORD_W(COORD_W)) u_db_match (
        .clk(clk), .rst_n(rst_n), .pos_x(pos_x), .pos_y(pos_y),
        .line(st_q.db_line), .fire(fire_db)
    );

    line_match #(.COORD_W(COORD_W)) u_sb_match (
        .clk(clk), .rst_n(rst_n), .pos_x(pos_x), .pos_y(pos_y),
        .line(st_q.sb_line), .fire(fire_sb)
    );

    assign clr_we  = wr_en && (addr == ADDR_W'(ADR_CLEAR));
    assign mask_we = wr_en && (addr == ADDR_W'(ADR_MASK));

    evt_status #(.N_LINES(N_LINES)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (line_evt),
        .clr_we   (clr_we),
        .clr_bits (wdata[N_LINES-1:0]),
        .mask_we  (mask_we),
        .mask_wr  (wdata[N_LINES-1:0]),
        .status_q (status_q),
        .mask_q   (mask_q),
        .irq_q    (irq)
    );

    always_comb begin
        st_d = st_q;
        st_d.pulse_db = fire_db && frame_run;
        st_d.pulse_sb = fire_sb && frame_run;

        if (wr_en) begin
            if (addr == ADDR_W'(ADR_RELOAD)) begin
                st_d.db_line = wdata[DB_LSB +: COORD_W];
                st_d.sb_line = wdata[SB_LSB +: COORD_W];
            end
            for (int i = 0; i < N_LINES; i++) begin
                if (addr == ADDR_W'(ADR_LINE_BASE + i))
                    st_d.line[i] = wdata[LINE_LSB +: COORD_W];
            end
        end

        if (rd_en) begin
            st_d.rdata = '0;
            if (addr == ADDR_W'(ADR_STATUS))
                st_d.rdata[N_LINES-1:0] = status_q;
            if (addr == ADDR_W'(ADR_MASK))
                st_d.rdata[N_LINES-1:0] = mask_q;
            if (addr == ADDR_W'(ADR_RELOAD)) begin
                st_d.rdata[DB_LSB +: COORD_W] = st_q.db_line;
                st_d.rdata[SB_LSB +: COORD_W] = st_q.sb_line;
            end
            for (int i = 0; i < N_LINES; i++) begin
                if (addr == ADDR_W'(ADR_LINE_BASE + i))
                    st_d.rdata[LINE_LSB +: COORD_W] = st_q.line[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata     = st_q.rdata;
    assign reload_db = st_q.pulse_db;
    assign reload_sb = st_q.pulse_sb;
endmodule

// File: rtl/lec_checker.sv
module lec_checker #(
    parameter int N_LINES = 4,
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  wdata,
    input logic               frame_run,
    input logic [N_LINES-1:0] evt,
    input logic [N_LINES-1:0] status,
    input logic [N_LINES-1:0] mask,
    input logic               irq,
    input logic               reload_sb,
    input logic               reload_db
);
    import lec_pkg::*;

    logic [N_LINES-1:0] clr;
    assign clr = (wr_en && addr == ADDR_W'(ADR_CLEAR)) ? wdata[N_LINES-1:0] : '0;

    for (genvar i = 0; i < N_LINES; i++) begin : g_bit
        // R4 and R6: an event always leaves its bit set
        assert_evt_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> status[i]);
        assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !evt[i]) |=> !status[i]);
        assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !clr[i]) |=> status[i]);
    end

    assert_irq_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & mask)) |=> irq);
    assert_irq_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status & mask)) |=> !irq);
    assert_db_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reload_db |=> !reload_db);
    assert_sb_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reload_sb |=> !reload_sb);
    assert_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_run |=> (!reload_db && !reload_sb));
endmodule

bind line_event_ctrl lec_checker #(
    .N_LINES(N_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .frame_run (frame_run),
    .evt       (line_evt),
    .status    (status_q),
    .mask      (mask_q),
    .irq       (irq),
    .reload_sb (reload_sb),
    .reload_db (reload_db)
);

// File: tb/line_event_ctrl_tb.sv
module line_event_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] pos_x = 13'd5;
    logic [12:0] pos_y = 13'd100;
    logic        frame_run = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, reload_sb, reload_db;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        logic [2:0]  a;
        string       tag;
    } item_t;
    item_t sbq[$];
    logic rd_pend = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_event_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .pos_x(pos_x), .pos_y(pos_y),
        .frame_run(frame_run), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq),
        .reload_sb(reload_sb), .reload_db(reload_db)
    );

    // monitor: compares read data against the scoreboard queue
    always @(posedge clk) rd_pend <= rd_en;
    always @(negedge clk) begin
        item_t it;
        if (rd_pend) begin
            n_chk++;
            if (sbq.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard empty: rdata %h expected none", rdata);
            end else begin
                it = sbq.pop_front();
                if (rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: addr %0d read %h expected %h", it.tag, it.a, rdata, it.exp);
                end
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step(input int x, input int y, input logic run);
        pos_x = 13'(x); pos_y = 13'(y); frame_run = run;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        wr_en = 1'b1; addr = 3'(a); wdata = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, input logic [31:0] exp, input string tag);
        item_t it;
        it.exp = exp; it.a = 3'(a); it.tag = tag;
        sbq.push_back(it);
        rd_en = 1'b1; addr = 3'(a);
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(irq, 1'b0, "R1 irq");
        chk(reload_db, 1'b0, "R1 reload_db");
        chk(reload_sb, 1'b0, "R1 reload_sb");
        rd(0, 32'h0, "R1 status");
        rd(2, 32'h0, "R1 mask");
        rd(3, 32'h0, "R1 reload lines");
        rd(4, 32'h0, "R1 line0");

        // R2 programming and readback
        wr(4, 32'd20 << 16);
        wr(5, 32'd0);
        wr(6, 32'hE007_FFFF);   // line 7 in 28:16, other bits dropped
        wr(7, 32'd30 << 16);
        wr(3, 32'h0002_0019);   // sb 2, db 25
        rd(6, 32'h0007_0000, "R2 line2 field");
        rd(3, 32'h0002_0019, "R2 reload fields");
        rd(1, 32'h0, "R2 clear reads zero");

        // R3/R4 event sets status while masked
        step(0, 20, 1'b1);
        step(0, 20, 1'b1);
        rd(0, 32'h1, "R4 status set while masked");
        chk(irq, 1'b0, "R4 masked irq low");
        wr(1, 32'h1);
        rd(0, 32'h0, "R3 no refire while held");

        // R10 line 0, R5 write zero no effect
        step(0, 0, 1'b1);
        rd(0, 32'h2, "R10 line zero event");
        wr(1, 32'h0);
        rd(0, 32'h2, "R5 write zero keeps bit");
        wr(1, 32'h2);
        rd(0, 32'h0, "R5 write one clears");

        // R7 stale status then unmask
        step(0, 7, 1'b1);
        step(5, 7, 1'b1);
        chk(irq, 1'b0, "R7 irq low before unmask");
        wr(2, 32'hFF);
        step(5, 7, 1'b1);
        chk(irq, 1'b1, "R7 stale status raises irq");
        rd(2, 32'hF, "R2 mask width");
        wr(1, 32'h4);
        step(5, 7, 1'b1);
        chk(irq, 1'b0, "R7 irq drops after clear");

        // R6 event and clear in the same cycle
        pos_x = 13'd0; pos_y = 13'd30;
        wr(1, 32'h8);
        rd(0, 32'h8, "R6 set wins over clear");
        chk(irq, 1'b1, "R7 irq from line3");
        wr(1, 32'h8);
        rd(0, 32'h0, "R6 later clear works");
        step(5, 30, 1'b1);

        // R8 reload pulses
        step(0, 25, 1'b1);
        chk(reload_db, 1'b1, "R8 db pulse");
        chk(reload_sb, 1'b0, "R8 sb quiet at db line");
        step(1, 25, 1'b1);
        chk(reload_db, 1'b0, "R8 db single cycle");
        step(0, 2, 1'b1);
        chk(reload_sb, 1'b1, "R8 sb pulse");
        chk(reload_db, 1'b0, "R8 db quiet at sb line");
        step(1, 2, 1'b1);
        chk(reload_sb, 1'b0, "R8 sb single cycle");

        // R9 gated by frame_run
        step(0, 25, 1'b0);
        chk(reload_db, 1'b0, "R9 db gated");
        step(0, 2, 1'b0);
        chk(reload_sb, 1'b0, "R9 sb gated");

        // R10 reload at line 0
        wr(3, 32'h0000_0019);
        step(5, 0, 1'b1);
        step(0, 0, 1'b1);
        chk(reload_sb, 1'b1, "R10 sb pulse at line zero");
        step(5, 0, 1'b1);
        step(5, 0, 1'b1);
        summary();
    end
endmodule